// File: doc/BRIEF.md
# Protocol Error Flag and Error Code Unit

This block sits beside a CAN protocol engine and collects the engine's error events. Each of eight event inputs is a single-cycle pulse; a pulse sets a sticky flag bit. Software masks the flags with an enable register. The block raises a summary error status bit when any set flag is also enabled, and that status is gated again by an interrupt enable bit to form the error interrupt line.

A second register records which kinds of bus error the engine has seen. Its top bit picks the recording mode. In accumulate mode each new error kind is OR-ed into what is already there. Otherwise the latest report replaces the whole field. Both the flags and the error kinds are cleared by software writing 0 to a bit. Writing 1 leaves that bit alone, so software can clear one bit without a read-modify-write race against hardware.

Top module: `err_flag_unit`

## Requirements
- R1: After reset, the flag, enable, error-code and interrupt-enable registers are all zero, and both `intStatus` and `errIrq` are low.
- R2: A pulse on `evtPulse[i]` sets flag bit i on the next clock edge, and the bit stays set until software clears it. The bits are, from 7 down to 0: bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: A write to address 0 clears every flag bit written as 0 and leaves every bit written as 1 unchanged.
- R4: When an event pulse and a software clear hit the same flag in the same cycle, the flag is set after the edge.
- R5: Address 1 is the enable register, with the same bit positions as the flags. It reads back as written, and a disabled event is still latched in the flag register.
- R6: `intStatus` bit 5 is 1 exactly when some flag bit and the same enable bit are both 1. All other `intStatus` bits are 0.
- R7: Address 3 is the interrupt enable register. `errIrq` equals `intStatus` bit 5 AND interrupt enable bit 5.
- R8: At address 2, bit 7 of the error-code register is the mode bit and reads back as written. Bits 6 to 0 clear when written as 0 and keep their value when written as 1. The bits are, from 6 down to 0: ACK delimiter, dominant bit, recessive bit, CRC, ACK, form, stuff.
- R9: With the mode bit set, a nonzero `errType` is OR-ed into bits 6 to 0. A same-cycle write clear is applied first, and then the new kinds are OR-ed in.
- R10: With the mode bit clear, a nonzero `errType` replaces bits 6 to 0 entirely, whatever is written in the same cycle. An all-zero `errType` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtPulse | input | 8 | Single-cycle error event pulses |
| errType | input | 7 | Single-cycle bus error kind pulses |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 flags, 1 enable, 2 error code, 3 interrupt enable |
| wrData | input | 8 | Write data |
| flagsOut | output | 8 | Event flag register |
| enableOut | output | 8 | Flag enable register |
| codeOut | output | 8 | Error-code register (bit 7 mode) |
| irqEnOut | output | 8 | Interrupt enable register |
| intStatus | output | 8 | Interrupt status, bit 5 the error summary |
| errIrq | output | 1 | Gated error interrupt |

## Verification
The bench walks all 256 flag patterns and checks the summary against several enable masks. A summary built from the raw flags instead of the masked flags would report disabled events. The clear path is checked with mixed masks, so a design that toggled bits or cleared on 1 would leave the wrong bits set. Each pattern also fires one event in the same cycle as a clear-all, which catches a design that gives the clear priority. Error kinds are swept in both recording modes, so a replace that merged or an accumulate that overwrote shows up in the code register.

// File: rtl/err_flag_pkg.sv
package err_flag_pkg;
  localparam int REG_W = 8;

  typedef struct packed {
    logic             wrFlags;
    logic             wrEnable;
    logic             wrCode;
    logic             wrIrqEn;
    logic [REG_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/err_flag_ctrl.sv
module err_flag_ctrl
  import err_flag_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output strobe_t           strobe
);
  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_CODE   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_IRQEN  = ADDR_W'(3);

  always_comb begin
    strobe.wrFlags  = wrEn && (wrAddr == ADDR_FLAGS);
    strobe.wrEnable = wrEn && (wrAddr == ADDR_ENABLE);
    strobe.wrCode   = wrEn && (wrAddr == ADDR_CODE);
    strobe.wrIrqEn  = wrEn && (wrAddr == ADDR_IRQEN);
    strobe.data     = wrData;
  end
endmodule

// File: rtl/err_flag_dp.sv
module err_flag_dp
  import err_flag_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int NUM_CODES = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strobe,
  input  logic [NUM_FLAGS-1:0] evtPulse,
  input  logic [NUM_CODES-1:0] errType,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [NUM_FLAGS-1:0] enQ,
  output logic [NUM_CODES-1:0] codeQ,
  output logic                 modeQ,
  output logic [REG_W-1:0]     irqEnQ
);
  localparam int MODE_BIT = NUM_CODES;

  logic [NUM_FLAGS-1:0] flagNext;
  logic [NUM_CODES-1:0] codeBase;
  logic [NUM_CODES-1:0] codeNext;

  // per-bit flag: software clear-by-zero, then the event sets it
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic keep;
    assign keep        = strobe.wrFlags ? (flagQ[i] & strobe.data[i]) : flagQ[i];
    assign flagNext[i] = keep | evtPulse[i];
  end

  always_comb begin
    codeBase = strobe.wrCode ? (codeQ & strobe.data[NUM_CODES-1:0]) : codeQ;
    if (|errType)
      codeNext = modeQ ? (codeBase | errType) : errType;
    else
      codeNext = codeBase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagQ  <= '0;
      enQ    <= '0;
      codeQ  <= '0;
      modeQ  <= 1'b0;
      irqEnQ <= '0;
    end else begin
      flagQ <= flagNext;
      codeQ <= codeNext;
      if (strobe.wrEnable) enQ <= strobe.data[NUM_FLAGS-1:0];
      if (strobe.wrIrqEn)  irqEnQ <= strobe.data;
      if (strobe.wrCode)   modeQ <= strobe.data[MODE_BIT];
    end
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evtPulse) |=> ((flagQ & $past(evtPulse)) == $past(evtPulse)));

  assert_clear_by_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrFlags && evtPulse == '0) |=>
      (flagQ == ($past(flagQ) & $past(strobe.data[NUM_FLAGS-1:0]))));

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.wrFlags && evtPulse == '0) |=> $stable(flagQ));

  assert_accumulate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ && (|errType) && !strobe.wrCode) |=>
      (codeQ == ($past(codeQ) | $past(errType))));

  assert_replace_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeQ && (|errType)) |=> (codeQ == $past(errType)));
endmodule

// File: rtl/err_flag_unit.sv
module err_flag_unit
  import err_flag_pkg::*;
#(
  parameter int NUM_FLAGS   = 8,
  parameter int NUM_CODES   = 7,
  parameter int ADDR_W      = 2,
  parameter int SUMMARY_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evtPulse,
  input  logic [NUM_CODES-1:0] errType,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [REG_W-1:0]     wrData,
  output logic [NUM_FLAGS-1:0] flagsOut,
  output logic [NUM_FLAGS-1:0] enableOut,
  output logic [NUM_CODES:0]   codeOut,
  output logic [REG_W-1:0]     irqEnOut,
  output logic [REG_W-1:0]     intStatus,
  output logic                 errIrq
);
  strobe_t              strobe;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] enQ;
  logic [NUM_CODES-1:0] codeQ;
  logic                 modeQ;
  logic [REG_W-1:0]     irqEnQ;
  logic                 summary;

  err_flag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe)
  );

  err_flag_dp #(.NUM_FLAGS(NUM_FLAGS), .NUM_CODES(NUM_CODES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .evtPulse (evtPulse),
    .errType  (errType),
    .flagQ    (flagQ),
    .enQ      (enQ),
    .codeQ    (codeQ),
    .modeQ    (modeQ),
    .irqEnQ   (irqEnQ)
  );

  assign summary = |(flagQ & enQ);

  for (genvar b = 0; b < REG_W; b++) begin : g_status
    if (b == SUMMARY_BIT) begin : g_sum
      assign intStatus[b] = summary;
    end else begin : g_zero
      assign intStatus[b] = 1'b0;
    end
  end

  assign errIrq    = summary & irqEnQ[SUMMARY_BIT];
  assign flagsOut  = flagQ;
  assign enableOut = enQ;
  assign codeOut   = {modeQ, codeQ};
  assign irqEnOut  = irqEnQ;

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    errIrq |-> (irqEnOut[SUMMARY_BIT] && intStatus[SUMMARY_BIT]));

  assert_no_enabled_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enableOut == '0) |-> !intStatus[SUMMARY_BIT]);
endmodule

// File: tb/tb_err_flag_unit.sv
module tb_err_flag_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] evtPulse = 0;
  logic [6:0] errType = 0;
  logic       wrEn = 0;
  logic [1:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] flagsOut, enableOut, codeOut, irqEnOut, intStatus;
  logic       errIrq;

  int total = 0;
  int bad = 0;

  logic [7:0] mFlags = 0, mEn = 0, mIrq = 0;
  logic [6:0] mCode = 0;
  logic       mMode = 0;

  err_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .evtPulse(evtPulse), .errType(errType),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .flagsOut(flagsOut), .enableOut(enableOut), .codeOut(codeOut),
    .irqEnOut(irqEnOut), .intStatus(intStatus), .errIrq(errIrq)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model update from the inputs currently driven, then one clock
  task automatic tick();
    logic [7:0] fKeep;
    logic [6:0] cBase;
    if (rst_n) begin
      fKeep = (wrEn && wrAddr == 0) ? (mFlags & wrData) : mFlags;
      cBase = (wrEn && wrAddr == 2) ? (mCode & wrData[6:0]) : mCode;
      mFlags = fKeep | evtPulse;
      if (errType != 0) mCode = mMode ? (cBase | errType) : errType;
      else mCode = cBase;
      if (wrEn && wrAddr == 1) mEn = wrData;
      if (wrEn && wrAddr == 3) mIrq = wrData;
      if (wrEn && wrAddr == 2) mMode = wrData[7];
    end
    @(posedge clk);
    #1;
    evtPulse = 0; errType = 0; wrEn = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    tick();
  endtask

  task automatic checkAll(input string req);
    logic sum;
    sum = |(mFlags & mEn);
    check(req, flagsOut, mFlags);
    check(req, enableOut, mEn);
    check(req, codeOut, {mMode, mCode});
    check(req, intStatus, {2'b00, sum, 5'b0});
    check(req, {7'b0, errIrq}, {7'b0, sum & mIrq[5]});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", flagsOut, 8'h00);
    check("R1", enableOut, 8'h00);
    check("R1", codeOut, 8'h00);
    check("R1", irqEnOut, 8'h00);
    check("R1", intStatus, 8'h00);
    check("R1", {7'b0, errIrq}, 8'h00);
    rst_n = 1;
    tick();

    // R5: disabled event still latched, no summary
    evtPulse = 8'h81; tick();
    check("R5", flagsOut, 8'h81);
    check("R5", intStatus, 8'h00);
    wr(3, 8'h20);
    check("R7", irqEnOut, 8'h20);

    for (int p = 0; p < 256; p++) begin
      wr(0, 8'h00);
      evtPulse = 8'(p); tick();
      check("R2", flagsOut, 8'(p));
      wr(1, 8'(p * 37 + 11));
      check("R5", enableOut, 8'(p * 37 + 11));
      checkAll("R6");
      if (p % 3 == 0) wr(3, 8'h00); else wr(3, 8'hFF);
      checkAll("R7");
      wr(0, 8'(p ^ 8'h5A));
      check("R3", flagsOut, 8'(p) & 8'(p ^ 8'h5A));
      wrEn = 1; wrAddr = 0; wrData = 8'h00; evtPulse = 8'(1 << (p % 8));
      tick();
      check("R4", flagsOut, 8'(1 << (p % 8)));
      checkAll("R6");
    end

    // R10: replace mode, all kinds
    wr(2, 8'h00);
    for (int t = 1; t < 128; t++) begin
      errType = 7'(t); tick();
      check("R10", codeOut, {1'b0, 7'(t)});
      tick();
      check("R10", codeOut, {1'b0, 7'(t)});
      wrEn = 1; wrAddr = 2; wrData = 8'h7F; errType = 7'(t ^ 7'h2B);
      if ((t ^ 7'h2B) != 0) begin
        tick();
        check("R10", codeOut, {1'b0, 7'(t ^ 7'h2B)});
      end else begin
        tick();
        checkAll("R10");
      end
    end

    // R8: mode bit readback and clear-by-zero
    wr(2, 8'h80);
    check("R8", codeOut, {1'b1, mCode});
    errType = 7'h7F; tick();
    check("R9", codeOut, 8'hFF);
    wr(2, 8'hA5);
    check("R8", codeOut, 8'hA5);
    wr(2, 8'hFF);
    check("R8", codeOut, 8'hA5);

    // R9: accumulate with same-cycle clear and single kinds
    for (int t = 0; t < 128; t++) begin
      wr(2, 8'h80);
      errType = 7'(1 << (t % 7)); tick();
      errType = 7'(t); tick();
      check("R9", codeOut, {1'b1, 7'(t) | 7'(1 << (t % 7))});
      wrEn = 1; wrAddr = 2; wrData = 8'h80 | 8'(t >> 1); errType = 7'(1 << ((t + 3) % 7));
      tick();
      checkAll("R9");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule